// File: doc/BRIEF.md
# Two-Wire Controller Interrupt Flag Block

This block holds the event flags of a two-wire serial bus controller and turns them into an interrupt request and two DMA requests. The bus engine reports what happened on the wire as single-cycle strobes: a byte arrived, the transmit holder was emptied, an address matched, a NACK or stop was seen, or an error occurred (bus error, arbitration lost, overrun, packet error check failure, timeout, alert). Each strobe sets a status flag that software can see in a read-only status word.

Flags are cleared in two ways, depending on the flag. The data flags follow the data registers: reading the receive data word clears the receive-full flag, and writing the transmit data word clears both transmit flags. The event and error flags are cleared by writing ones to a write-only clear word. A peripheral-enable control bit, when low, forces the data flags to their idle values. A parameter removes the three SMBus-only flags, so that they never set.

Software reaches the block through a plain register bus with single-cycle read and write strobes and combinational read data. A control word holds the enable, the no-stretch bit and the two DMA enables, and an enable word masks the flags onto the interrupt line.

Top module: `i2c_flag_regs`

## Requirements
- R1: After reset the control and enable words read 0, the status word reads 0x0001 (only the transmit-empty flag, bit 0, set), and the interrupt and both DMA requests are low.
- R2: A receive strobe while enabled captures the byte into the receive data word (offset 0x24) and sets status bit 2; a read of that word returns the byte and clears bit 2 on the same clock edge.
- R3: A transmit-empty strobe while enabled sets status bits 0 and 1; a write to the transmit data word (offset 0x28) drives the byte on `tx_byte` and clears bits 0 and 1.
- R4: Writing 1 to status bit 0 (status word at offset 0x18) sets the transmit-empty flag; writing 1 to status bit 1 sets the transmit-request flag only when control bit 1 (no-stretch) is 1, and has no effect otherwise.
- R5: While control bit 0 (enable) is 0, status bit 0 is held at 1 and bits 1 and 2 are held at 0, whatever the strobes and writes.
- R6: Writing the clear word (offset 0x1C) clears each flag whose clear bit is 1: bit 3 address match, 4 NACK, 5 stop, 8 bus error, 9 arbitration lost, 10 overrun, 11 packet check error, 12 timeout, 13 alert (same positions in the status word); a 0 bit leaves the flag unchanged.
- R7: When a set strobe and a clear for the same flag fall in the same cycle, the flag ends set.
- R8: With SMBus support disabled by parameter, status bits 11, 12 and 13 never set and read 0.
- R9: `irq` is a register equal to the OR over all bits of status AND the enable word (offset 0x04, same bit layout), one cycle after the flags change.
- R10: `dma_tx_req` is control bit 2 AND status bit 1, and `dma_rx_req` is control bit 3 AND status bit 2, both registered one cycle after their inputs.
- R11: Reading the clear word returns 0, and reading the status word changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives side effects) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| ev_rx_valid | input | 1 | Engine delivered a received byte |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_empty | input | 1 | Engine took the transmit byte; holder empty |
| ev_addr_hit | input | 1 | Own address matched |
| ev_nack | input | 1 | NACK received |
| ev_stop | input | 1 | Stop condition seen |
| ev_bus_err | input | 1 | Misplaced start or stop |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_overrun | input | 1 | Overrun or underrun |
| ev_pkt_err | input | 1 | Packet error check mismatch |
| ev_timeout | input | 1 | Clock-low timeout |
| ev_alert | input | 1 | Alert line asserted |
| periph_en | output | 1 | Control enable bit to the engine |
| no_stretch | output | 1 | Control no-stretch bit to the engine |
| tx_byte | output | 8 | Transmit data word |
| irq | output | 1 | Registered interrupt request |
| dma_tx_req | output | 1 | Registered transmit DMA request |
| dma_rx_req | output | 1 | Registered receive DMA request |

## Verification
The bench builds two copies side by side on one shared bus and event set: `dut` with SMBus support enabled and `dut_ns` with it compiled out. Every vector of the event table is checked against both, so the same strobe pattern shows the alert, timeout and packet check flags setting in one copy and staying at zero in the other. The default address and data widths keep every offset and clear bit reachable.

// File: rtl/i2c_flag_pkg.sv
// Shared constants for the two-wire controller flag block.
// Assumes a byte-addressed register bus; flag bit positions are shared
// between the status word, the clear word and the enable word.
package i2c_flag_pkg;

    localparam int FLAG_W = 14;

    localparam int F_TX_EMPTY = 0;
    localparam int F_TX_REQ   = 1;
    localparam int F_RX_FULL  = 2;
    localparam int F_ADDR_HIT = 3;
    localparam int F_NACK     = 4;
    localparam int F_STOP     = 5;
    localparam int F_BUS_ERR  = 8;
    localparam int F_ARB_LOST = 9;
    localparam int F_OVERRUN  = 10;
    localparam int F_PKT_ERR  = 11;
    localparam int F_TIMEOUT  = 12;
    localparam int F_ALERT    = 13;

    // flags cleared through the clear word
    localparam logic [FLAG_W-1:0] CLR_MASK = 14'h3F38;
    // flags that exist only with SMBus support
    localparam logic [FLAG_W-1:0] SMB_MASK = 14'h3800;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_IE     = 'h04;
    localparam int OFS_STATUS = 'h18;
    localparam int OFS_CLEAR  = 'h1C;
    localparam int OFS_RXDATA = 'h24;
    localparam int OFS_TXDATA = 'h28;

    localparam int CTRL_W = 4;

    typedef struct packed {
        logic rxdma_en;   // bit 3
        logic txdma_en;   // bit 2
        logic nostretch;  // bit 1
        logic pe;         // bit 0
    } ctrl_t;

endpackage

// File: rtl/i2c_flag_decode.sv
// Register bus decoder: turns address plus strobes into per-register
// write and read-side-effect strobes, and muxes the read data.
// Assumes single-cycle strobes; write-only words read as zero.
module i2c_flag_decode
    import i2c_flag_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] ctrl_word,
    input  logic [DW-1:0] ie_word,
    input  logic [DW-1:0] status_word,
    input  logic [DW-1:0] rx_word,
    output logic          we_ctrl,
    output logic          we_ie,
    output logic          we_status,
    output logic          we_clear,
    output logic          we_txdata,
    output logic          rd_rxdata,
    output logic [DW-1:0] bus_rdata
);

    logic hit_ctrl, hit_ie, hit_status, hit_clear, hit_rx, hit_tx;

    // address match per register
    always_comb begin
        hit_ctrl   = (bus_addr == AW'(OFS_CTRL));
        hit_ie     = (bus_addr == AW'(OFS_IE));
        hit_status = (bus_addr == AW'(OFS_STATUS));
        hit_clear  = (bus_addr == AW'(OFS_CLEAR));
        hit_rx     = (bus_addr == AW'(OFS_RXDATA));
        hit_tx     = (bus_addr == AW'(OFS_TXDATA));
    end

    // write and read-side-effect strobes
    always_comb begin
        we_ctrl   = bus_wr & hit_ctrl;
        we_ie     = bus_wr & hit_ie;
        we_status = bus_wr & hit_status;
        we_clear  = bus_wr & hit_clear;
        we_txdata = bus_wr & hit_tx;
        rd_rxdata = bus_rd & hit_rx;
    end

    // read data mux; clear and transmit words are write-only
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)   bus_rdata = ctrl_word;
        if (hit_ie)     bus_rdata = ie_word;
        if (hit_status) bus_rdata = status_word;
        if (hit_rx)     bus_rdata = rx_word;
    end

endmodule

// File: rtl/i2c_flag_cell.sv
// One event flag: set by a hardware strobe, cleared by a clear pulse,
// set taking priority. When IMPL is 0 the flag is absent and reads 0.
module i2c_flag_cell #(
    parameter bit IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    if (IMPL) begin : g_flag
        logic q;

        // flag register, set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n)     q <= 1'b0;
            else if (set_i) q <= 1'b1;
            else if (clr_i) q <= 1'b0;
        end

        assign flag_o = q;

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> flag_o);

        assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !flag_o);

        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && !set_i) |=> $stable(flag_o));
    end else begin : g_absent
        logic unused_in;
        assign unused_in = set_i ^ clr_i ^ clk ^ rst_n;
        assign flag_o = 1'b0;
    end

endmodule

// File: rtl/i2c_flag_req.sv
// Request generator: registers the masked OR of the flags onto the
// interrupt line and the data flags onto the two DMA request lines.
// Assumes flags and enables are already registered upstream.
module i2c_flag_req
    import i2c_flag_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flags,
    input  logic [FW-1:0] ie,
    input  logic          txdma_en,
    input  logic          rxdma_en,
    output logic          irq,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);

    // one-cycle registered request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            dma_tx_req <= 1'b0;
            dma_rx_req <= 1'b0;
        end else begin
            irq        <= |(flags & ie);
            dma_tx_req <= txdma_en & flags[F_TX_REQ];
            dma_rx_req <= rxdma_en & flags[F_RX_FULL];
        end
    end

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(flags & ie)));

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> !$past(|(flags & ie)));

    assert_dma_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_tx_req) |-> $past(txdma_en && flags[F_TX_REQ]));

    assert_dma_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rx_req) |-> $past(rxdma_en && flags[F_RX_FULL]));

endmodule

// File: rtl/i2c_flag_regs.sv
// Flag and request block of a two-wire bus controller. Holds control,
// enable, status, clear and data words; the bus engine reports events as
// single-cycle strobes. Assumes DW >= 14 and strobes synchronous to clk.
module i2c_flag_regs
    import i2c_flag_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter bit SMB_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ev_rx_valid,
    input  logic [7:0]    ev_rx_byte,
    input  logic          ev_tx_empty,
    input  logic          ev_addr_hit,
    input  logic          ev_nack,
    input  logic          ev_stop,
    input  logic          ev_bus_err,
    input  logic          ev_arb_lost,
    input  logic          ev_overrun,
    input  logic          ev_pkt_err,
    input  logic          ev_timeout,
    input  logic          ev_alert,
    output logic          periph_en,
    output logic          no_stretch,
    output logic [7:0]    tx_byte,
    output logic          irq,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);

    ctrl_t             ctrl_q;
    logic [FLAG_W-1:0] ie_q;
    logic [7:0]        rx_q;
    logic [7:0]        tx_q;
    logic              txe_q, txreq_q, rxfull_q;
    logic [FLAG_W-1:0] evt_set, evt_clr, evt_flags, flags;
    logic              we_ctrl, we_ie, we_status, we_clear, we_txdata, rd_rxdata;
    logic [DW-1:0]     ctrl_word, ie_word, status_word, rx_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:FLAG_W];

    assign ctrl_word   = {{(DW-CTRL_W){1'b0}}, ctrl_q};
    assign ie_word     = {{(DW-FLAG_W){1'b0}}, ie_q};
    assign status_word = {{(DW-FLAG_W){1'b0}}, flags};
    assign rx_word     = {{(DW-8){1'b0}}, rx_q};

    i2c_flag_decode #(.AW(AW), .DW(DW)) u_decode (
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .ctrl_word   (ctrl_word),
        .ie_word     (ie_word),
        .status_word (status_word),
        .rx_word     (rx_word),
        .we_ctrl     (we_ctrl),
        .we_ie       (we_ie),
        .we_status   (we_status),
        .we_clear    (we_clear),
        .we_txdata   (we_txdata),
        .rd_rxdata   (rd_rxdata),
        .bus_rdata   (bus_rdata)
    );

    // control word
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (we_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // interrupt enable word
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (we_ie) ie_q <= bus_wdata[FLAG_W-1:0];
    end

    // receive data capture
    always_ff @(posedge clk) begin
        if (!rst_n)                        rx_q <= '0;
        else if (ev_rx_valid && ctrl_q.pe) rx_q <= ev_rx_byte;
    end

    // transmit data word
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (we_txdata) tx_q <= bus_wdata[7:0];
    end

    // transmit-empty flag: forced set while disabled, flushable by software
    always_ff @(posedge clk) begin
        if (!rst_n)                 txe_q <= 1'b1;
        else if (!ctrl_q.pe)        txe_q <= 1'b1;
        else if (ev_tx_empty || (we_status && bus_wdata[F_TX_EMPTY]))
                                    txe_q <= 1'b1;
        else if (we_txdata)         txe_q <= 1'b0;
    end

    // transmit-request flag: software set only with stretching off
    always_ff @(posedge clk) begin
        if (!rst_n)                 txreq_q <= 1'b0;
        else if (!ctrl_q.pe)        txreq_q <= 1'b0;
        else if (ev_tx_empty ||
                 (we_status && bus_wdata[F_TX_REQ] && ctrl_q.nostretch))
                                    txreq_q <= 1'b1;
        else if (we_txdata)         txreq_q <= 1'b0;
    end

    // receive-full flag: cleared by reading the receive data word
    always_ff @(posedge clk) begin
        if (!rst_n)           rxfull_q <= 1'b0;
        else if (!ctrl_q.pe)  rxfull_q <= 1'b0;
        else if (ev_rx_valid) rxfull_q <= 1'b1;
        else if (rd_rxdata)   rxfull_q <= 1'b0;
    end

    // event set strobes at their status positions
    always_comb begin
        evt_set             = '0;
        evt_set[F_ADDR_HIT] = ev_addr_hit;
        evt_set[F_NACK]     = ev_nack;
        evt_set[F_STOP]     = ev_stop;
        evt_set[F_BUS_ERR]  = ev_bus_err;
        evt_set[F_ARB_LOST] = ev_arb_lost;
        evt_set[F_OVERRUN]  = ev_overrun;
        evt_set[F_PKT_ERR]  = ev_pkt_err;
        evt_set[F_TIMEOUT]  = ev_timeout;
        evt_set[F_ALERT]    = ev_alert;
    end

    // write-one-to-clear pulses, reserved bits dropped
    always_comb begin
        evt_clr = we_clear ? (bus_wdata[FLAG_W-1:0] & CLR_MASK) : '0;
    end

    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_evt
        if (CLR_MASK[gi]) begin : g_cell
            localparam bit CELL_IMPL = SMB_MASK[gi] ? SMB_EN : 1'b1;
            i2c_flag_cell #(.IMPL(CELL_IMPL)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt_set[gi]),
                .clr_i  (evt_clr[gi]),
                .flag_o (evt_flags[gi])
            );
        end else begin : g_none
            assign evt_flags[gi] = 1'b0;
        end
    end

    // assemble the status word
    always_comb begin
        flags             = evt_flags;
        flags[F_TX_EMPTY] = txe_q;
        flags[F_TX_REQ]   = txreq_q;
        flags[F_RX_FULL]  = rxfull_q;
    end

    i2c_flag_req #(.FW(FLAG_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (flags),
        .ie         (ie_q),
        .txdma_en   (ctrl_q.txdma_en),
        .rxdma_en   (ctrl_q.rxdma_en),
        .irq        (irq),
        .dma_tx_req (dma_tx_req),
        .dma_rx_req (dma_rx_req)
    );

    assign periph_en  = ctrl_q.pe;
    assign no_stretch = ctrl_q.nostretch;
    assign tx_byte    = tx_q;

    assert_disable_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (txe_q && !txreq_q && !rxfull_q));

    assert_rx_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxdata && !ev_rx_valid) |=> !rxfull_q);

    assert_tx_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_txdata && !ev_tx_empty && !(we_status && bus_wdata[1:0] != 2'b00) && periph_en)
        |=> (!txe_q && !txreq_q));

    assert_stretch_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_stretch && !ev_tx_empty && !txreq_q) |=> !txreq_q);

    assert_clear_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'(OFS_CLEAR)) |-> (bus_rdata == '0));

    if (!SMB_EN) begin : g_nosmb_chk
        assert_smb_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags & SMB_MASK) == '0);
    end

endmodule

// File: tb/tb_i2c_flag_regs.sv
`timescale 1ns/1ps
module tb_i2c_flag_regs;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          ev_rx_valid = 0, ev_tx_empty = 0, ev_addr_hit = 0, ev_nack = 0;
    logic          ev_stop = 0, ev_bus_err = 0, ev_arb_lost = 0, ev_overrun = 0;
    logic          ev_pkt_err = 0, ev_timeout = 0, ev_alert = 0;
    logic [7:0]    ev_rx_byte = 8'h00;

    logic [DW-1:0] rdata_a, rdata_b;
    logic          pe_a, ns_a, irq_a, dtx_a, drx_a;
    logic          pe_b, ns_b, irq_b, dtx_b, drx_b;
    logic [7:0]    txb_a, txb_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_flag_regs #(.AW(AW), .DW(DW), .SMB_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .ev_rx_valid(ev_rx_valid),
        .ev_rx_byte(ev_rx_byte), .ev_tx_empty(ev_tx_empty), .ev_addr_hit(ev_addr_hit),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_bus_err(ev_bus_err),
        .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun), .ev_pkt_err(ev_pkt_err),
        .ev_timeout(ev_timeout), .ev_alert(ev_alert), .periph_en(pe_a),
        .no_stretch(ns_a), .tx_byte(txb_a), .irq(irq_a), .dma_tx_req(dtx_a),
        .dma_rx_req(drx_a));

    i2c_flag_regs #(.AW(AW), .DW(DW), .SMB_EN(1'b0)) dut_ns (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .ev_rx_valid(ev_rx_valid),
        .ev_rx_byte(ev_rx_byte), .ev_tx_empty(ev_tx_empty), .ev_addr_hit(ev_addr_hit),
        .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_bus_err(ev_bus_err),
        .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun), .ev_pkt_err(ev_pkt_err),
        .ev_timeout(ev_timeout), .ev_alert(ev_alert), .periph_en(pe_b),
        .no_stretch(ns_b), .tx_byte(txb_b), .irq(irq_b), .dma_tx_req(dtx_b),
        .dma_rx_req(drx_b));

    localparam logic [7:0] A_CTRL = 8'h00, A_IE = 8'h04, A_STAT = 8'h18;
    localparam logic [7:0] A_CLR = 8'h1C, A_RX = 8'h24, A_TX = 8'h28;
    localparam logic [13:0] SMB_BITS = 14'h3800;

    typedef struct packed {
        logic [13:0] ev;
        logic [13:0] exp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{14'h0008, 14'h0008},
        '{14'h0030, 14'h0030},
        '{14'h0300, 14'h0300},
        '{14'h3C00, 14'h3C00},
        '{14'h0004, 14'h0004},
        '{14'h0001, 14'h0003},
        '{14'h3F3F, 14'h3F3F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_ev(input logic [13:0] m);
        ev_tx_empty = m[0] | m[1];
        ev_rx_valid = m[2];
        ev_addr_hit = m[3];
        ev_nack     = m[4];
        ev_stop     = m[5];
        ev_bus_err  = m[8];
        ev_arb_lost = m[9];
        ev_overrun  = m[10];
        ev_pkt_err  = m[11];
        ev_timeout  = m[12];
        ev_alert    = m[13];
    endtask

    task automatic pulse(input logic [13:0] m);
        @(negedge clk);
        drive_ev(m);
        @(negedge clk);
        drive_ev(14'h0);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        da = rdata_a; db = rdata_b;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb, ra2, rb2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_STAT, ra, rb);
        check("R1 status", ra, 32'h1);
        check("R1 status nosmb", rb, 32'h1);
        bus_read(A_CTRL, ra, rb);
        check("R1 ctrl", ra, 32'h0);
        bus_read(A_IE, ra, rb);
        check("R1 ie", ra, 32'h0);
        check("R1 requests", {29'h0, irq_a, dtx_a, drx_a}, 32'h0);

        bus_write(A_CTRL, 32'h1);
        bus_write(A_TX, 32'h00);
        bus_read(A_STAT, ra, rb);
        check("R3 baseline cleared", ra, 32'h0);

        // table walk: event strobes to status, both builds (R2 R3 R6 R8)
        for (int i = 0; i < 7; i++) begin
            pulse(VEC[i].ev);
            bus_read(A_STAT, ra, rb);
            check("R6 table status", ra, {18'h0, VEC[i].exp});
            check("R8 table status nosmb", rb, {18'h0, VEC[i].exp & ~SMB_BITS});
            bus_write(A_CLR, 32'h3F38);
            bus_read(A_RX, ra, rb);
            bus_write(A_TX, 32'h0);
            bus_read(A_STAT, ra, rb);
            check("R6 table restored", ra, 32'h0);
        end

        // R2 receive byte and read-to-clear
        ev_rx_byte = 8'hA5;
        pulse(14'h0004);
        bus_read(A_RX, ra, rb);
        check("R2 rx byte", ra, 32'hA5);
        bus_read(A_STAT, ra, rb);
        check("R2 rx flag cleared", ra, 32'h0);

        // R11 status read has no side effect; clear word reads 0
        pulse(14'h0008);
        bus_read(A_STAT, ra, rb);
        bus_read(A_STAT, ra2, rb2);
        check("R11 status reread", ra2, 32'h8);
        bus_read(A_CLR, ra, rb);
        check("R11 clear reads zero", ra, 32'h0);
        bus_read(A_STAT, ra, rb);
        check("R11 status kept", ra, 32'h8);

        // R6 zeros have no effect, only matching bit clears
        bus_write(A_CLR, 32'h0);
        bus_read(A_STAT, ra, rb);
        check("R6 zero write", ra, 32'h8);
        bus_write(A_CLR, 32'h10);
        bus_read(A_STAT, ra, rb);
        check("R6 other bit", ra, 32'h8);
        bus_write(A_CLR, 32'h8);
        bus_read(A_STAT, ra, rb);
        check("R6 matching bit", ra, 32'h0);

        // R7 set and clear in the same cycle
        @(negedge clk);
        ev_nack = 1'b1;
        bus_addr = A_CLR; bus_wdata = 32'h10; bus_wr = 1'b1;
        @(negedge clk);
        ev_nack = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        bus_read(A_STAT, ra, rb);
        check("R7 set wins", ra, 32'h10);
        bus_write(A_CLR, 32'h10);

        // R9 interrupt one cycle after the flag
        bus_write(A_IE, 32'h10);
        pulse(14'h0010);
        check("R9 irq not yet", {31'h0, irq_a}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'h0, irq_a}, 32'h1);
        bus_write(A_CLR, 32'h10);
        check("R9 irq still high", {31'h0, irq_a}, 32'h1);
        @(negedge clk);
        check("R9 irq dropped", {31'h0, irq_a}, 32'h0);

        // R4 software set of transmit flags
        bus_write(A_STAT, 32'h2);
        bus_read(A_STAT, ra, rb);
        check("R4 blocked with stretching", ra, 32'h0);
        bus_write(A_CTRL, 32'h3);
        bus_write(A_STAT, 32'h2);
        bus_read(A_STAT, ra, rb);
        check("R4 set with no-stretch", ra, 32'h2);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, ra, rb);
        check("R4 flush sets empty", ra, 32'h3);

        // R10 transmit DMA request
        bus_write(A_CTRL, 32'h7);
        check("R10 tx dma not yet", {31'h0, dtx_a}, 32'h0);
        @(negedge clk);
        check("R10 tx dma raised", {31'h0, dtx_a}, 32'h1);

        // R3 transmit write clears both flags
        bus_write(A_TX, 32'h5C);
        check("R3 tx byte", {24'h0, txb_a}, 32'h5C);
        bus_read(A_STAT, ra, rb);
        check("R3 tx flags cleared", ra, 32'h0);
        check("R10 tx dma dropped", {31'h0, dtx_a}, 32'h0);

        // R10 receive DMA request
        bus_write(A_CTRL, 32'h9);
        pulse(14'h0004);
        @(negedge clk);
        check("R10 rx dma raised", {31'h0, drx_a}, 32'h1);

        // R5 disable forces data flags
        bus_write(A_CTRL, 32'h0);
        bus_read(A_STAT, ra, rb);
        check("R5 forced on disable", ra, 32'h1);
        pulse(14'h0004);
        bus_write(A_STAT, 32'h2);
        bus_read(A_STAT, ra, rb);
        check("R5 held while disabled", ra, 32'h1);
        check("R5 nosmb held", rb, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule